// File: doc/BRIEF.md
# SPI Message Sequencer with Inter-Transfer Delays

This block drives a byte-wide SPI shift engine through a queued message made of one or more transfers. A message header supplies the clock mode and clock divider for the target device. Each transfer descriptor, popped from a show-ahead FIFO, gives a byte count, whether transmit bytes come from a transmit FIFO, whether received bytes go to a receive sink, a post-transfer delay in microseconds, a flag that says whether chip select is released after the transfer, and a marker for the final transfer of the message.

The sequencer controls the active-low chip select. Where a transfer has no transmit data it sends filler bytes. When the engine reports a write collision it repeats the last byte. When the engine reports a mode fault it abandons the message. After each transfer it waits out the programmed delay on a microsecond timebase. The timebase comes from a cycles-per-microsecond parameter, and its comparison tolerates counter wrap. When a message ends it emits a one-cycle completion pulse with an error bit and the number of bytes the completed transfers moved.

Top module: `spi_msg_seq`

## Requirements
- R1: After reset, chip select is high (`cs_n`=1), `done`, `eng_wr`, `tx_pop`, `rx_push` and `spurious` are 0, and `msg_ready` is 1.
- R2: Accepting a message pulses `eng_cfg_load` for one cycle with `eng_mode` and `eng_clkdiv` equal to the header values. The first transfer then always drives `cs_n` low, and `cs_n` is low whenever a byte is written to the engine.
- R3: For a transfer with transmit data, the bytes written are the transmit FIFO head values in order, and each one pops the FIFO. Without transmit data, every byte written is 0x00 and nothing is popped.
- R4: For a transfer with its receive flag set, each byte-done pushes `eng_rdata` to `rx_byte`. With the flag clear, nothing is pushed.
- R5: A collision indication during a transfer rewrites the byte last written, pops nothing, and does not count toward the transfer length.
- R6: A mode fault during a transfer raises `cs_n`, emits `done` with `done_err`=1, and returns to idle. `done_len` then counts only the transfers completed before the fault.
- R7: A transfer of length N ends after N byte-done indications (collisions excluded), so N+c bytes are written for c collisions.
- R8: After the last byte-done of a transfer with delay D microseconds, the next step (next transfer or completion) follows after at least (D-1)·CYC_PER_US+1 and at most D·CYC_PER_US+3 cycles.
- R9: Between transfers of one message, `cs_n` goes high for at least one cycle if the finished transfer had its release flag set, and stays low otherwise.
- R10: After the final transfer's delay, `cs_n` goes high and a single-cycle `done` with `done_err`=0 is emitted. `done_len` is the sum of the transfer lengths.
- R11: A byte-done outside a transfer (idle, fetch or wait) pulses `spurious` and has no other effect: nothing is pushed or completed, and the next message runs normally.
- R12: The delay of R8 holds regardless of where the free-running microsecond counter stands, including across its wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message header available |
| msg_ready | output | 1 | Header accepted this cycle when valid (idle) |
| msg_mode | input | 3 | Clock mode bits for the target device |
| msg_clkdiv | input | DIV_W | Clock divider for the target device |
| xfer_valid | input | 1 | Transfer descriptor FIFO not empty |
| xfer_ready | output | 1 | Descriptor popped this cycle when valid |
| xfer_len | input | LEN_W | Bytes in the transfer (at least 1) |
| xfer_has_tx | input | 1 | Transmit bytes come from the transmit FIFO |
| xfer_has_rx | input | 1 | Received bytes go to the receive sink |
| xfer_delay_us | input | DLY_W | Delay after the transfer, microseconds |
| xfer_cs_change | input | 1 | Release chip select after this transfer |
| xfer_last | input | 1 | Final transfer of the message |
| tx_data | input | 8 | Transmit FIFO head (show-ahead) |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_push | output | 1 | Received byte valid |
| rx_byte | output | 8 | Received byte |
| eng_cfg_load | output | 1 | Load mode and divider into the engine |
| eng_mode | output | 3 | Mode for the engine |
| eng_clkdiv | output | DIV_W | Divider for the engine |
| eng_wr | output | 1 | Write a byte to the engine |
| eng_wdata | output | 8 | Byte to shift out |
| eng_done | input | 1 | Engine finished a byte |
| eng_rdata | input | 8 | Byte shifted in |
| eng_wcol | input | 1 | Engine reports a write collision |
| eng_modf | input | 1 | Engine reports a mode fault |
| cs_n | output | 1 | Chip select, active low |
| done | output | 1 | Message complete pulse |
| done_err | output | 1 | Message ended by a mode fault |
| done_len | output | ACC_W | Bytes moved by completed transfers |
| spurious | output | 1 | Byte-done seen outside a transfer |

## Verification
The table-driven pass runs single-transfer messages that vary length, transmit and receive presence, delay, and the byte position of an injected collision or mode fault. This separates filler from sourced data, resent bytes from fresh ones, and an aborted count from a completed one. Multi-transfer messages then differ only in the release flag, which shows whether chip select is held or dropped between transfers. A run of back-to-back delayed messages measures the wait while the microsecond counter wraps. A lone byte-done while idle must raise only the spurious flag.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FILL_BYTE = '0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/spi_seq_ustimer.sv
`timescale 1ns/1ps
// Free-running microsecond counter plus a deadline register; the
// expiry test uses the sign of (now - deadline) so wrap is harmless.
module spi_seq_ustimer #(
  parameter int CYC_PER_US = 100,
  parameter int DLY_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] delay_us,
  output logic             expired
);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int NOW_W = DLY_W + 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre;
  logic [NOW_W-1:0] now_us;
  logic [NOW_W-1:0] deadline;
  logic [NOW_W-1:0] diff;
  logic             tick;

  assign tick = (pre == PRE_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= '0;
      now_us   <= '0;
      deadline <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) now_us <= now_us + 1'b1;
      if (load) deadline <= now_us + NOW_W'(delay_us);
    end
  end

  assign diff    = now_us - deadline;
  assign expired = ~diff[NOW_W-1];
endmodule

// File: rtl/spi_seq_txpath.sv
`timescale 1ns/1ps
// Outgoing byte register: new byte from FIFO or filler, or a repeat
// of the byte already held after a collision.
module spi_seq_txpath
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              send_new,
  input  logic              resend,
  input  logic              has_tx,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              eng_wr,
  output logic [BYTE_W-1:0] eng_wdata,
  output logic              tx_pop
);
  always_ff @(posedge clk) begin
    if (rst) begin
      eng_wr    <= 1'b0;
      eng_wdata <= FILL_BYTE;
      tx_pop    <= 1'b0;
    end else begin
      eng_wr <= send_new | resend;
      tx_pop <= send_new & has_tx;
      if (send_new) eng_wdata <= has_tx ? tx_data : FILL_BYTE;
    end
  end
endmodule

// File: rtl/spi_seq_lencnt.sv
`timescale 1ns/1ps
// Remaining-byte counter for the current transfer and the message
// byte accumulator.
module spi_seq_lencnt #(
  parameter int LEN_W = 16,
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic             dec,
  input  logic             commit,
  output logic             last_byte,
  output logic [ACC_W-1:0] acc,
  output logic [ACC_W-1:0] acc_plus
);
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      cur <= '0;
      acc <= '0;
    end else begin
      if (clear)       acc <= '0;
      else if (commit) acc <= acc_plus;
      if (start) begin
        rem <= len_in;
        cur <= len_in;
      end else if (dec) begin
        rem <= rem - 1'b1;
      end
    end
  end

  assign last_byte = (rem <= LEN_W'(1));
  assign acc_plus  = acc + ACC_W'(cur);
endmodule

// File: rtl/spi_msg_seq.sv
`timescale 1ns/1ps
module spi_msg_seq
  import spi_seq_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int DLY_W      = 12,
  parameter int ACC_W      = 20,
  parameter int DIV_W      = 8,
  parameter int CYC_PER_US = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [2:0]       msg_mode,
  input  logic [DIV_W-1:0] msg_clkdiv,
  input  logic             xfer_valid,
  output logic             xfer_ready,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             xfer_has_tx,
  input  logic             xfer_has_rx,
  input  logic [DLY_W-1:0] xfer_delay_us,
  input  logic             xfer_cs_change,
  input  logic             xfer_last,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             eng_cfg_load,
  output logic [2:0]       eng_mode,
  output logic [DIV_W-1:0] eng_clkdiv,
  output logic             eng_wr,
  output logic [7:0]       eng_wdata,
  input  logic             eng_done,
  input  logic [7:0]       eng_rdata,
  input  logic             eng_wcol,
  input  logic             eng_modf,
  output logic             cs_n,
  output logic             done,
  output logic             done_err,
  output logic [ACC_W-1:0] done_len,
  output logic             spurious
);
  seq_state_e st, st_n;

  logic             carry_cs;
  logic             cur_has_tx;
  logic             cur_has_rx;
  logic             cur_last;
  logic [DLY_W-1:0] cur_delay;

  logic accept_msg, accept_x, in_x;
  logic ev_wcol, ev_modf, ev_byte, end_x, wait_done;
  logic send_new, has_tx_sel;
  logic last_byte, expired;
  logic [ACC_W-1:0] acc, acc_plus;

  assign msg_ready  = (st == ST_IDLE);
  assign xfer_ready = (st == ST_FETCH);
  assign accept_msg = msg_ready & msg_valid;
  assign accept_x   = xfer_ready & xfer_valid;
  assign in_x       = (st == ST_XFER);
  // priority inside a transfer: collision, then fault, then byte done
  assign ev_wcol    = in_x & eng_wcol;
  assign ev_modf    = in_x & ~eng_wcol & eng_modf;
  assign ev_byte    = in_x & ~eng_wcol & ~eng_modf & eng_done;
  assign end_x      = ev_byte & last_byte;
  assign wait_done  = (st == ST_WAIT) & expired;
  assign send_new   = accept_x | (ev_byte & ~last_byte);
  assign has_tx_sel = accept_x ? xfer_has_tx : cur_has_tx;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:  if (msg_valid) st_n = ST_FETCH;
      ST_FETCH: if (xfer_valid) st_n = ST_XFER;
      ST_XFER: begin
        if (ev_modf)    st_n = ST_IDLE;
        else if (end_x) st_n = ST_WAIT;
      end
      ST_WAIT:  if (expired) st_n = cur_last ? ST_IDLE : ST_FETCH;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      carry_cs     <= 1'b0;
      cur_has_tx   <= 1'b0;
      cur_has_rx   <= 1'b0;
      cur_last     <= 1'b0;
      cur_delay    <= '0;
      cs_n         <= 1'b1;
      done         <= 1'b0;
      done_err     <= 1'b0;
      done_len     <= '0;
      spurious     <= 1'b0;
      rx_push      <= 1'b0;
      rx_byte      <= '0;
      eng_cfg_load <= 1'b0;
      eng_mode     <= '0;
      eng_clkdiv   <= '0;
    end else begin
      st           <= st_n;
      eng_cfg_load <= accept_msg;
      done         <= ev_modf | (wait_done & cur_last);
      spurious     <= eng_done & ~in_x;
      rx_push      <= ev_byte & cur_has_rx;
      if (ev_byte) rx_byte <= eng_rdata;

      if (accept_msg) begin
        eng_mode   <= msg_mode;
        eng_clkdiv <= msg_clkdiv;
        carry_cs   <= 1'b1;
      end

      if (accept_x) begin
        cur_has_tx <= xfer_has_tx;
        cur_has_rx <= xfer_has_rx;
        cur_last   <= xfer_last;
        cur_delay  <= xfer_delay_us;
        carry_cs   <= xfer_cs_change;
        if (carry_cs) cs_n <= 1'b0;
      end

      if (ev_modf) begin
        cs_n     <= 1'b1;
        done_err <= 1'b1;
        done_len <= acc;
      end else if (wait_done) begin
        if (cur_last || carry_cs) cs_n <= 1'b1;
        if (cur_last) begin
          done_err <= 1'b0;
          done_len <= acc_plus;
        end
      end
    end
  end

  spi_seq_txpath u_txpath (
    .clk       (clk),
    .rst       (rst),
    .send_new  (send_new),
    .resend    (ev_wcol),
    .has_tx    (has_tx_sel),
    .tx_data   (tx_data),
    .eng_wr    (eng_wr),
    .eng_wdata (eng_wdata),
    .tx_pop    (tx_pop)
  );

  spi_seq_lencnt #(.LEN_W(LEN_W), .ACC_W(ACC_W)) u_lencnt (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept_msg),
    .start     (accept_x),
    .len_in    (xfer_len),
    .dec       (ev_byte),
    .commit    (wait_done),
    .last_byte (last_byte),
    .acc       (acc),
    .acc_plus  (acc_plus)
  );

  spi_seq_ustimer #(.CYC_PER_US(CYC_PER_US), .DLY_W(DLY_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (end_x),
    .delay_us (cur_delay),
    .expired  (expired)
  );
endmodule

// File: rtl/spi_msg_seq_chk.sv
`timescale 1ns/1ps
module spi_msg_seq_chk
  import spi_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input seq_state_e st,
  input logic       eng_wcol,
  input logic       eng_modf,
  input logic       eng_done,
  input logic       eng_wr,
  input logic [7:0] eng_wdata,
  input logic       tx_pop,
  input logic       rx_push,
  input logic       cs_n,
  input logic       done,
  input logic       done_err,
  input logic       spurious
);
  a_r1_cs_high_idle: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> cs_n);

  a_r3_pop_needs_write: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> eng_wr);

  a_r4_push_after_done: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> $past(eng_done));

  a_r5_wcol_resend: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER && eng_wcol) |=> (eng_wr && $stable(eng_wdata) && !tx_pop));

  a_r6_modf_abort: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER && !eng_wcol && eng_modf) |=> (cs_n && done && done_err));

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_spurious_flag: assert property (@(posedge clk) disable iff (rst)
    (eng_done && st != ST_XFER) |=> (spurious && !rx_push));
endmodule

bind spi_msg_seq spi_msg_seq_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .st        (st),
  .eng_wcol  (eng_wcol),
  .eng_modf  (eng_modf),
  .eng_done  (eng_done),
  .eng_wr    (eng_wr),
  .eng_wdata (eng_wdata),
  .tx_pop    (tx_pop),
  .rx_push   (rx_push),
  .cs_n      (cs_n),
  .done      (done),
  .done_err  (done_err),
  .spurious  (spurious)
);

// File: tb/spi_msg_seq_tb.sv
`timescale 1ns/1ps
module spi_msg_seq_tb_top;
  localparam int LEN_W = 8;
  localparam int DLY_W = 4;
  localparam int ACC_W = 12;
  localparam int DIV_W = 8;
  localparam int CYC   = 4;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             msg_valid = 1'b0;
  logic             msg_ready;
  logic [2:0]       msg_mode = '0;
  logic [DIV_W-1:0] msg_clkdiv = '0;
  logic             xfer_valid = 1'b0;
  logic             xfer_ready;
  logic [LEN_W-1:0] xfer_len = '0;
  logic             xfer_has_tx = 1'b0, xfer_has_rx = 1'b0;
  logic [DLY_W-1:0] xfer_delay_us = '0;
  logic             xfer_cs_change = 1'b0, xfer_last = 1'b0;
  logic [7:0]       tx_data = '0;
  logic             tx_pop, rx_push;
  logic [7:0]       rx_byte;
  logic             eng_cfg_load;
  logic [2:0]       eng_mode;
  logic [DIV_W-1:0] eng_clkdiv;
  logic             eng_wr;
  logic [7:0]       eng_wdata;
  logic             eng_done = 1'b0, eng_wcol = 1'b0, eng_modf = 1'b0;
  logic [7:0]       eng_rdata = '0;
  logic             cs_n, done, done_err, spurious;
  logic [ACC_W-1:0] done_len;

  spi_msg_seq #(.LEN_W(LEN_W), .DLY_W(DLY_W), .ACC_W(ACC_W), .DIV_W(DIV_W),
                .CYC_PER_US(CYC)) dut_i (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_mode(msg_mode), .msg_clkdiv(msg_clkdiv), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_len(xfer_len), .xfer_has_tx(xfer_has_tx),
    .xfer_has_rx(xfer_has_rx), .xfer_delay_us(xfer_delay_us),
    .xfer_cs_change(xfer_cs_change), .xfer_last(xfer_last), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .eng_cfg_load(eng_cfg_load), .eng_mode(eng_mode), .eng_clkdiv(eng_clkdiv),
    .eng_wr(eng_wr), .eng_wdata(eng_wdata), .eng_done(eng_done),
    .eng_rdata(eng_rdata), .eng_wcol(eng_wcol), .eng_modf(eng_modf),
    .cs_n(cs_n), .done(done), .done_err(done_err), .done_len(done_len),
    .spurious(spurious)
  );

  int total = 0, bad = 0;

  function automatic logic [7:0] tx_val(input int i);
    return 8'((8'h21 + 13 * i) & 8'hFF);
  endfunction

  // descriptor store (task writes entries and dcnt; model owns dptr)
  int d_len[0:63], d_tx[0:63], d_rx[0:63], d_dly[0:63], d_csc[0:63], d_last[0:63];
  int dcnt = 0, dptr = 0;
  bit xpend = 0;
  int wcol_at = -1, modf_at = -1;
  int spur_req = 0, spur_ack = 0;

  // model-owned logs
  int cyc = 0, tx_ptr = 0, widx = 0, eng_cd = 0, rx_cnt = 0;
  logic [7:0] wr_data[0:255];
  logic [7:0] rx_data[0:255];
  int cs_bad = 0, done_cnt = 0, done_err_s = 0, done_len_s = 0, done_cyc = 0;
  int lastdone_cyc = 0, spur_cnt = 0, cs_rise = 0, cfg_cnt = 0, mode_s = 0, div_s = 0;
  logic cs_prev = 1'b1;

  always @(negedge clk) begin
    cyc++;
    eng_done = 1'b0;
    eng_wcol = 1'b0;
    eng_modf = 1'b0;
    if (!rst) begin
      if (tx_pop) tx_ptr++;
      if (eng_wr) begin
        wr_data[widx] = eng_wdata;
        if (cs_n) cs_bad++;
        widx++;
        eng_cd = LAT;
      end else if (eng_cd > 0) begin
        eng_cd--;
        if (eng_cd == 0) begin
          if (widx - 1 == modf_at) eng_modf = 1'b1;
          else if (widx - 1 == wcol_at) eng_wcol = 1'b1;
          else begin
            eng_done  = 1'b1;
            eng_rdata = wr_data[widx - 1] ^ 8'hA5;
            lastdone_cyc = cyc;
          end
        end
      end
      if (rx_push) begin rx_data[rx_cnt] = rx_byte; rx_cnt++; end
      if (done) begin
        done_cnt++; done_err_s = int'(done_err); done_len_s = int'(done_len); done_cyc = cyc;
      end
      if (spurious) spur_cnt++;
      if (cs_n && !cs_prev) cs_rise++;
      cs_prev = cs_n;
      if (eng_cfg_load) begin cfg_cnt++; mode_s = int'(eng_mode); div_s = int'(eng_clkdiv); end
      if (spur_req != spur_ack) begin spur_ack++; eng_done = 1'b1; end
      if (xpend) dptr++;
      xfer_valid     = (dptr < dcnt);
      xfer_len       = LEN_W'(d_len[dptr]);
      xfer_has_tx    = d_tx[dptr][0];
      xfer_has_rx    = d_rx[dptr][0];
      xfer_delay_us  = DLY_W'(d_dly[dptr]);
      xfer_cs_change = d_csc[dptr][0];
      xfer_last      = d_last[dptr][0];
      xpend = xfer_ready && xfer_valid;
    end
    tx_data = tx_val(tx_ptr);
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic add_desc(input int len, input int tx, input int rx, input int dly,
                          input int csc, input int last);
    d_len[dcnt] = len; d_tx[dcnt] = tx; d_rx[dcnt] = rx;
    d_dly[dcnt] = dly; d_csc[dcnt] = csc; d_last[dcnt] = last;
    dcnt++;
  endtask

  task automatic send_msg(input int mode, input int div);
    int d0;
    d0 = done_cnt;
    @(negedge clk);
    msg_mode = 3'(mode); msg_clkdiv = DIV_W'(div); msg_valid = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
    for (int k = 0; k < 3000 && done_cnt == d0; k++) @(negedge clk);
    chk("R10 message completion seen", int'(done_cnt > d0), 1);
  endtask

  // stimulus/expected table: len, has_tx, has_rx, delay, wcol_idx, modf_idx, exp_err, exp_len
  localparam int NV = 6;
  localparam int VT [0:NV-1][0:7] = '{
    '{1, 1, 1, 0, -1, -1, 0, 1},
    '{4, 0, 1, 1, -1, -1, 0, 4},
    '{3, 1, 0, 2,  1, -1, 0, 3},
    '{5, 1, 1, 3, -1,  2, 1, 0},
    '{2, 0, 0, 0,  0, -1, 0, 2},
    '{6, 1, 1, 5, -1, -1, 0, 6}
  };

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n after reset", int'(cs_n), 1);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 eng_wr after reset", int'(eng_wr), 0);
    chk("R1 pops/pushes after reset", int'(tx_pop | rx_push | spurious), 0);
    chk("R1 msg_ready after reset", int'(msg_ready), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int w0, r0, t0, c0, b0, len, dly, nw, nrx, mism, gap, lo, hi, bidx;
      len = VT[v][0]; dly = VT[v][3];
      w0 = widx; r0 = rx_cnt; t0 = tx_ptr; c0 = cfg_cnt; b0 = cs_bad;
      wcol_at = (VT[v][4] >= 0) ? w0 + VT[v][4] : -1;
      modf_at = (VT[v][5] >= 0) ? w0 + VT[v][5] : -1;
      add_desc(len, VT[v][1], VT[v][2], dly, 0, 1);
      send_msg(v, v + 3);
      repeat (2) @(negedge clk);
      chk("R2 config load count", cfg_cnt - c0, 1);
      chk("R2 mode and divider", mode_s * 256 + div_s, v * 256 + v + 3);
      chk("R2 cs low at each write", cs_bad - b0, 0);
      chk("R6/R10 done_err", done_err_s, VT[v][6]);
      chk("R6/R10 done_len", done_len_s, VT[v][7]);
      chk("R1/R6/R10 cs_n high after message", int'(cs_n), 1);
      nw = (VT[v][5] >= 0) ? VT[v][5] + 1 : len + ((VT[v][4] >= 0) ? 1 : 0);
      chk("R5/R7 byte writes", widx - w0, nw);
      nrx = VT[v][2] ? ((VT[v][5] >= 0) ? VT[v][5] : len) : 0;
      chk("R4 received pushes", rx_cnt - r0, nrx);
      mism = 0;
      for (int i = 0; i < nw; i++) begin
        logic [7:0] ev;
        bidx = (VT[v][4] >= 0 && i > VT[v][4]) ? i - 1 : i;
        ev = VT[v][1] ? tx_val(t0 + bidx) : 8'h00;
        if (wr_data[w0 + i] !== ev) mism++;
      end
      chk("R3/R5 written byte values", mism, 0);
      mism = 0;
      for (int i = 0; i < nrx; i++) begin
        logic [7:0] ev;
        ev = (VT[v][1] ? tx_val(t0 + i) : 8'h00) ^ 8'hA5;
        if (rx_data[r0 + i] !== ev) mism++;
      end
      chk("R4 received byte values", mism, 0);
      if (VT[v][5] < 0) begin
        gap = done_cyc - lastdone_cyc;
        lo = (dly == 0) ? 1 : (dly - 1) * CYC + 1;
        hi = dly * CYC + 3;
        if (gap < lo || gap > hi)
          $display("FAIL R8 delay gap actual=%0d expected=%0d..%0d", gap, lo, hi);
        total++; if (gap < lo || gap > hi) bad++;
      end
      wcol_at = -1; modf_at = -1;
    end

    // R9: release after first transfer, hold after second
    begin
      int c0, w0, b0;
      c0 = cs_rise; w0 = widx; b0 = cs_bad;
      add_desc(2, 1, 1, 0, 1, 0);
      add_desc(1, 1, 1, 1, 0, 0);
      add_desc(3, 1, 1, 0, 0, 1);
      send_msg(1, 5);
      repeat (2) @(negedge clk);
      chk("R9 cs rises with release flag", cs_rise - c0, 2);
      chk("R10 multi-transfer done_len", done_len_s, 6);
      chk("R10 multi-transfer done_err", done_err_s, 0);
      chk("R7 multi-transfer writes", widx - w0, 6);
      chk("R2 cs low at writes", cs_bad - b0, 0);
    end
    // R9: hold chip select across all transfers
    begin
      int c0;
      c0 = cs_rise;
      add_desc(2, 0, 1, 1, 0, 0);
      add_desc(2, 1, 0, 0, 0, 1);
      send_msg(2, 6);
      repeat (2) @(negedge clk);
      chk("R9 cs held between transfers", cs_rise - c0, 1);
      chk("R10 held-cs done_len", done_len_s, 4);
    end
    // R6: fault in second transfer; only the first counts
    begin
      int w0;
      w0 = widx;
      modf_at = w0 + 3;
      add_desc(2, 1, 1, 0, 0, 0);
      add_desc(3, 1, 1, 0, 0, 1);
      send_msg(3, 7);
      repeat (2) @(negedge clk);
      chk("R6 fault done_err", done_err_s, 1);
      chk("R6 fault done_len", done_len_s, 2);
      chk("R6 cs high after fault", int'(cs_n), 1);
      modf_at = -1;
    end
    // R11: byte-done while idle
    begin
      int s0, r0, d0;
      s0 = spur_cnt; r0 = rx_cnt; d0 = done_cnt;
      spur_req++;
      repeat (4) @(negedge clk);
      chk("R11 spurious flagged", spur_cnt - s0, 1);
      chk("R11 no push or completion", (rx_cnt - r0) + (done_cnt - d0), 0);
      chk("R11 cs stays high", int'(cs_n), 1);
      add_desc(2, 1, 1, 0, 0, 1);
      send_msg(4, 8);
      repeat (2) @(negedge clk);
      chk("R11 next message normal", done_len_s * 2 + done_err_s, 4);
    end
    // R12: repeated delays across counter wrap
    for (int m = 0; m < 10; m++) begin
      int gap, lo, hi;
      add_desc(1, 0, 0, 7, 0, 1);
      send_msg(0, 2);
      gap = done_cyc - lastdone_cyc;
      lo = 6 * CYC + 1; hi = 7 * CYC + 3;
      total++;
      if (gap < lo || gap > hi) begin
        bad++;
        $display("FAIL R12 wrapped delay gap actual=%0d expected=%0d..%0d", gap, lo, hi);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule